// File: doc/BRIEF.md
# Two-Pixel Span Depth Tester

This block performs the depth-buffer side of filling one horizontal span of a shaded polygon. The depth memory stores two 16-bit depths in each 32-bit word. The even pixel sits in the low half and the odd pixel in the high half. The block works through the span in two streaming passes, and each pass handles one word per clock.

In the test pass the block fetches each word of the span. It steps two 16.8 fixed-point depth interpolators, one for even pixels and one for odd pixels. It compares each interpolated depth with the stored depth for that pixel and saves a two-bit "closer" mark per word in a small local store. In the write pass the block restarts both interpolators from their saved start values. It then sends one write per word, carrying both new depths and a per-half byte-lane mask taken from the saved marks. Because reads and writes are split into separate passes, the memory never sees a read-modify-write pair.

A colour stage that runs afterwards can read the saved marks through a plain index port. Spans wider than the mark store must be split by the caller.

The memory sides use valid/ready rules:
- A read request (`rd_req_valid`, `rd_addr`) is held unchanged until `rd_req_ready` is high at a clock edge.
- Read responses return in request order on `rd_rsp_valid`/`rd_rsp_data`. They are always accepted, so the block applies no back-pressure to them.
- A write (`wr_valid`, `wr_addr`, `wr_data`, `wr_be`) is held unchanged until `wr_ready` is high at a clock edge.

Top module: `zspan_depth_unit`

## Requirements
- R1: A start is accepted only while idle and only with a span length from 1 to 128. After it is accepted, `busy` is high from the next cycle. Any other start, including length 0 or a length above 128, leaves the block idle with no memory requests. While idle, `rd_req_valid` and `wr_valid` are low.
- R2: The test pass issues exactly ceil(len/2) read requests to word addresses base, base+1, and so on in order. The base is `x_left` shifted right by one, so bit 0 of `x_left` is ignored. A request that is stalled keeps `rd_addr` unchanged.
- R3: For word i, the even depth is bits [23:8] of the 24-bit wrapping sum z0 + i*dz0. The odd depth is bits [23:8] of z1 + i*dz1. The fraction bits play no part in the comparison.
- R4: The even pixel's mark (bit 0) is set only when its depth is strictly less than `rd_data[15:0]`. The odd pixel's mark (bit 1) is set only when its depth is strictly less than `rd_data[31:16]`. Equal depths are not closer.
- R5: When the span length is odd, the odd mark of the last word is forced to 0, so that half is never written.
- R6: `test_done` is a one-cycle pulse, exactly once per span, in the first cycle of the write pass. No read is issued while a write is pending.
- R7: The write pass issues one write per span word, to the same addresses in the same order. `wr_data` is {odd depth, even depth} recomputed as in R3. `wr_be` equals the word's marks, with bit 0 for the low half and bit 1 for the high half. A stalled write holds all of its fields.
- R8: `write_done` is a one-cycle pulse in the first cycle after the last write is accepted, and `busy` is low in that same cycle.
- R9: After reset every mark reads 0. After a test pass, `flag_rdata` shows the marks of word index `flag_raddr` (0 = the first word of the span) with no clock delay.
- R10: A start raised while `busy` is high has no effect on the running span's addresses, data, masks or length.
- R11: With both ready inputs held high and a read latency of one cycle, `test_done` rises n+1 clocks after the start edge. `write_done` rises 2n+1 clocks after the start edge, where n = ceil(len/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to process one span |
| x_left | input | 16 | Pixel index of the leftmost pixel; bit 0 is ignored |
| span_len | input | 8 | Number of pixels in the span, 1 to 128 |
| z0_init | input | 24 | Even-pixel start depth, 16.8 fixed point |
| z1_init | input | 24 | Odd-pixel start depth, 16.8 fixed point |
| dz0 | input | 24 | Even-pixel depth step per word |
| dz1 | input | 24 | Odd-pixel depth step per word |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 15 | Word address of the read |
| rd_rsp_valid | input | 1 | Read data valid, returned in request order |
| rd_rsp_data | input | 32 | Stored depths: odd pixel in [31:16], even pixel in [15:0] |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 15 | Word address of the write |
| wr_data | output | 32 | New depths: odd pixel in [31:16], even pixel in [15:0] |
| wr_be | output | 2 | Half-word enables: bit 0 low half, bit 1 high half |
| flag_raddr | input | 6 | Word index of the mark to read |
| flag_rdata | output | 2 | Marks of that word: bit 0 even, bit 1 odd |
| busy | output | 1 | A span is in progress |
| test_done | output | 1 | One-cycle pulse when the test pass ends |
| write_done | output | 1 | One-cycle pulse when the write pass ends |

## Verification
The hardest situation to reach is a start request arriving in the middle of a span. That request must leave no trace in the running span.

The stimulus also needs a stall on either memory side that lands exactly when the interpolators reload between passes. The bench covers this with a few cases:
- A directed case raises `start` again, with a different base and start depth, a few cycles into a running span. The bench then compares the whole memory image with the model of the first span alone.
- Table rows drive pseudo-random ready patterns on the read side, the write side, or both, so that stalls fall on the pass boundary.
- Memory filled with one constant pattern makes the strict-less rule and the odd-length tail mask visible, both in the written memory and on the mark port.

// File: rtl/zspan_pkg.sv
package zspan_pkg;
  localparam int ZS_ZW         = 16;  // stored depth width
  localparam int ZS_FRAC       = 8;   // interpolator fraction bits
  localparam int ZS_FLAG_WORDS = 64;  // mark store depth in words
  localparam int ZS_XW         = 16;  // pixel index width

  typedef enum logic [1:0] {
    ZS_IDLE  = 2'd0,
    ZS_TEST  = 2'd1,
    ZS_WRITE = 2'd2
  } zs_state_e;
endpackage

// File: rtl/zspan_acc.sv
module zspan_acc #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init,
  input  logic [W-1:0] delta,
  output logic [W-1:0] value
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (load)  acc_q <= init;
    else if (step)  acc_q <= acc_q + delta;
  end

  assign value = acc_q;
endmodule

// File: rtl/zspan_flagbuf.sv
module zspan_flagbuf #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/zspan_depth_unit.sv
module zspan_depth_unit
  import zspan_pkg::*;
#(
  parameter int ZW         = ZS_ZW,
  parameter int FRAC       = ZS_FRAC,
  parameter int FLAG_WORDS = ZS_FLAG_WORDS,
  parameter int XW         = ZS_XW,
  localparam int ACCW      = ZW + FRAC,
  localparam int WAW       = XW - 1,
  localparam int FAW       = $clog2(FLAG_WORDS),
  localparam int CW        = FAW + 1,
  localparam int LW        = $clog2(2 * FLAG_WORDS) + 1,
  localparam int DW        = 2 * ZW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XW-1:0]   x_left,
  input  logic [LW-1:0]   span_len,
  input  logic [ACCW-1:0] z0_init,
  input  logic [ACCW-1:0] z1_init,
  input  logic [ACCW-1:0] dz0,
  input  logic [ACCW-1:0] dz1,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [WAW-1:0]  rd_addr,
  input  logic            rd_rsp_valid,
  input  logic [DW-1:0]   rd_rsp_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [WAW-1:0]  wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [1:0]      wr_be,
  input  logic [FAW-1:0]  flag_raddr,
  output logic [1:0]      flag_rdata,
  output logic            busy,
  output logic            test_done,
  output logic            write_done
);
  localparam int LANES = 2;

  zs_state_e       state_q;
  logic [WAW-1:0]  base_q;
  logic [CW-1:0]   nwords_q, req_cnt_q, rsp_cnt_q, wr_cnt_q;
  logic            odd_q;
  logic            test_done_q, write_done_q;
  logic [ACCW-1:0] z_start_q [LANES];
  logic [ACCW-1:0] dz_q      [LANES];
  logic [ACCW-1:0] z_port    [LANES];
  logic [ACCW-1:0] dz_port   [LANES];
  logic [ACCW-1:0] lane_init [LANES];
  logic [ACCW-1:0] lane_val  [LANES];
  logic [ZW-1:0]   depth     [LANES];
  logic [LANES-1:0] closer;

  logic [LW:0] words_full;
  logic        start_ok, rsp_fire, last_rsp, wr_fire, last_wr, rd_fire;
  logic        acc_load, acc_step;
  logic [1:0]  flag_wdata;

  assign z_port[0]  = z0_init;
  assign z_port[1]  = z1_init;
  assign dz_port[0] = dz0;
  assign dz_port[1] = dz1;

  assign words_full = ({1'b0, span_len} + (LW+1)'(1)) >> 1;
  assign start_ok   = (state_q == ZS_IDLE) && start && (span_len != '0)
                      && (span_len <= LW'(2 * FLAG_WORDS));

  assign rd_req_valid = (state_q == ZS_TEST) && (req_cnt_q < nwords_q);
  assign rd_addr      = base_q + WAW'(req_cnt_q);
  assign rd_fire      = rd_req_valid && rd_req_ready;

  assign rsp_fire = (state_q == ZS_TEST) && rd_rsp_valid && (rsp_cnt_q < nwords_q);
  assign last_rsp = (rsp_cnt_q == nwords_q - CW'(1));

  assign wr_valid = (state_q == ZS_WRITE);
  assign wr_addr  = base_q + WAW'(wr_cnt_q);
  assign wr_fire  = wr_valid && wr_ready;
  assign last_wr  = (wr_cnt_q == nwords_q - CW'(1));

  // Reload wins over step: last test response restarts the lanes for the write pass
  assign acc_load = start_ok || (rsp_fire && last_rsp);
  assign acc_step = rsp_fire || wr_fire;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_init[l] = start_ok ? z_port[l] : z_start_q[l];

    zspan_acc #(.W(ACCW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (acc_load),
      .step  (acc_step),
      .init  (lane_init[l]),
      .delta (dz_q[l]),
      .value (lane_val[l])
    );

    assign depth[l]  = lane_val[l][ACCW-1 -: ZW];
    assign closer[l] = depth[l] < rd_rsp_data[l*ZW +: ZW];
  end

  // Odd half of the final word lies past the span when the length is odd
  assign flag_wdata = {closer[1] & ~(last_rsp & odd_q), closer[0]};

  assign wr_data = {depth[1], depth[0]};

  zspan_flagbuf #(.DEPTH(FLAG_WORDS), .W(2)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rsp_fire),
    .waddr   (rsp_cnt_q[FAW-1:0]),
    .wdata   (flag_wdata),
    .raddr_a (wr_cnt_q[FAW-1:0]),
    .rdata_a (wr_be),
    .raddr_b (flag_raddr),
    .rdata_b (flag_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ZS_IDLE;
      base_q       <= '0;
      nwords_q     <= '0;
      odd_q        <= 1'b0;
      req_cnt_q    <= '0;
      rsp_cnt_q    <= '0;
      wr_cnt_q     <= '0;
      test_done_q  <= 1'b0;
      write_done_q <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        z_start_q[l] <= '0;
        dz_q[l]      <= '0;
      end
    end else begin
      test_done_q  <= 1'b0;
      write_done_q <= 1'b0;
      unique case (state_q)
        ZS_IDLE: begin
          if (start_ok) begin
            base_q    <= x_left[XW-1:1];
            nwords_q  <= words_full[CW-1:0];
            odd_q     <= span_len[0];
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            for (int l = 0; l < LANES; l++) begin
              z_start_q[l] <= z_port[l];
              dz_q[l]      <= dz_port[l];
            end
            state_q <= ZS_TEST;
          end
        end
        ZS_TEST: begin
          if (rd_fire) req_cnt_q <= req_cnt_q + CW'(1);
          if (rsp_fire) begin
            rsp_cnt_q <= rsp_cnt_q + CW'(1);
            if (last_rsp) begin
              state_q     <= ZS_WRITE;
              wr_cnt_q    <= '0;
              test_done_q <= 1'b1;
            end
          end
        end
        ZS_WRITE: begin
          if (wr_fire) begin
            wr_cnt_q <= wr_cnt_q + CW'(1);
            if (last_wr) begin
              state_q      <= ZS_IDLE;
              write_done_q <= 1'b1;
            end
          end
        end
        default: state_q <= ZS_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ZS_IDLE);
  assign test_done  = test_done_q;
  assign write_done = write_done_q;
endmodule

// File: rtl/zspan_checker.sv
module zspan_checker #(
  parameter int WAW = 15,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic [WAW-1:0] rd_addr,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [WAW-1:0] wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic [1:0]     wr_be,
  input logic           test_done,
  input logic           write_done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !wr_valid));                                   // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));   // R2
  AST_PASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));                                              // R6
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_done, write_done}));                                        // R6
  AST_TEST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> (busy && !$past(test_done)));                                // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)
                                 && $stable(wr_data) && $stable(wr_be)));      // R7
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + 1'b1))); // R7
  AST_WRITE_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |-> (!busy && $past(wr_valid && wr_ready)));                    // R8
endmodule

bind zspan_depth_unit zspan_checker #(.WAW(WAW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_be        (wr_be),
  .test_done    (test_done),
  .write_done   (write_done)
);

// File: tb/zspan_depth_unit_tb.sv
module zspan_depth_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] x_left = '0;
  logic [7:0]  span_len = '0;
  logic [23:0] z0_init = '0, z1_init = '0, dz0 = '0, dz1 = '0;
  logic        rd_req_valid, rd_req_ready = 1'b1;
  logic [14:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [14:0] wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  wr_be;
  logic [5:0]  flag_raddr = '0;
  logic [1:0]  flag_rdata;
  logic        busy, test_done, write_done;

  always #5 clk = ~clk;

  zspan_depth_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_left(x_left), .span_len(span_len),
    .z0_init(z0_init), .z1_init(z1_init), .dz0(dz0), .dz1(dz1),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .flag_raddr(flag_raddr), .flag_rdata(flag_rdata),
    .busy(busy), .test_done(test_done), .write_done(write_done)
  );

  int tests = 0;
  int fails = 0;

  logic [31:0] mem     [256];
  logic [31:0] exp_mem [256];
  logic [1:0]  exp_flag [64];

  // memory model and monitors
  logic [1:0]  mode = 2'd0;
  logic [7:0]  lfsr = 8'hA5;
  logic [14:0] exp_base = '0;
  int mon_rd = 0, mon_wr = 0, mon_td = 0, rd_addr_err = 0, wr_addr_err = 0;

  always @(negedge clk) begin
    lfsr         <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_req_ready <= mode[0] ? lfsr[0] : 1'b1;
    wr_ready     <= mode[1] ? lfsr[2] : 1'b1;
  end

  always @(posedge clk) begin
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= mem[rd_addr[7:0]];
    if (rd_req_valid && rd_req_ready) begin
      if (rd_addr != exp_base + 15'(mon_rd)) rd_addr_err++;
      mon_rd++;
    end
    if (wr_valid && wr_ready) begin
      if (wr_addr != exp_base + 15'(mon_wr)) wr_addr_err++;
      mon_wr++;
      if (wr_be[0]) mem[wr_addr[7:0]][15:0]  <= wr_data[15:0];
      if (wr_be[1]) mem[wr_addr[7:0]][31:16] <= wr_data[31:16];
    end
    if (test_done) mon_td++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic init_mem(input int seed);
    for (int w = 0; w < 256; w++) begin
      if (seed == 0)        mem[w] = {16'h2001, 16'h2000};
      else if (seed == 255) mem[w] = 32'hFFFF_FFFF;
      else begin
        mem[w][15:0]  = 16'h0F00 + 16'((w * 53 + seed * 17) % 512);
        mem[w][31:16] = 16'h0F80 + 16'((w * 29 + seed * 71) % 768);
      end
    end
  endtask

  task automatic run_span(input logic [15:0] xl, input logic [7:0] len,
                          input logic [23:0] a0, input logic [23:0] a1,
                          input logic [23:0] d0, input logic [23:0] d1,
                          input logic [1:0] md, input int seed, input bit poke);
    int n, cnt, td_at, mm;
    logic [14:0] base;
    logic [23:0] acc0, acc1;
    logic [15:0] e0, e1;
    logic [7:0]  wi;
    logic [31:0] bad_act, bad_exp;
    init_mem(seed);
    for (int w = 0; w < 256; w++) exp_mem[w] = mem[w];
    base = xl[15:1];
    n = (int'(len) + 1) / 2;
    // independent reference model of both passes
    for (int i = 0; i < n; i++) begin
      acc0 = a0 + 24'(i) * d0;
      acc1 = a1 + 24'(i) * d1;
      e0 = acc0[23:8];
      e1 = acc1[23:8];
      wi = 8'(base + 15'(i));
      exp_flag[i][0] = e0 < exp_mem[wi][15:0];
      exp_flag[i][1] = (2 * i + 1 < int'(len)) && (e1 < exp_mem[wi][31:16]);
      if (exp_flag[i][0]) exp_mem[wi][15:0]  = e0;
      if (exp_flag[i][1]) exp_mem[wi][31:16] = e1;
    end
    mode = md;
    exp_base = base;
    mon_rd = 0; mon_wr = 0; mon_td = 0; rd_addr_err = 0; wr_addr_err = 0;
    @(negedge clk);
    x_left = xl; span_len = len; z0_init = a0; z1_init = a1; dz0 = d0; dz1 = d1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    td_at = -1;
    while (!write_done && cnt < 4000) begin
      if (test_done) td_at = cnt;
      if (poke && cnt == 3) begin
        start = 1'b1; x_left = xl + 16'd40; z0_init = ~a0; span_len = 8'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(write_done, "R8", "write_done seen", 64'(write_done), 64'd1);
    check(!busy, "R8", "idle with write_done", 64'(busy), 64'd0);
    if (md == 2'd0) begin
      check(cnt == 2 * n + 2, "R11", "write_done latency", 64'(cnt - 1), 64'(2 * n + 1));
      check(td_at == n + 2, "R11", "test_done latency", 64'(td_at - 1), 64'(n + 1));
    end
    check(mon_rd == n, "R2", "read count", 64'(mon_rd), 64'(n));
    check(rd_addr_err == 0, "R2", "read address order", 64'(rd_addr_err), 64'd0);
    check(mon_wr == n, "R7", "write count", 64'(mon_wr), 64'(n));
    check(wr_addr_err == 0, "R7", "write address order", 64'(wr_addr_err), 64'd0);
    check(mon_td == 1, "R6", "test_done pulses", 64'(mon_td), 64'd1);
    mm = 0; bad_act = '0; bad_exp = '0;
    for (int w = 0; w < 256; w++)
      if (mem[w] !== exp_mem[w]) begin
        if (mm == 0) begin bad_act = mem[w]; bad_exp = exp_mem[w]; end
        mm++;
      end
    check(mm == 0, poke ? "R10" : "R3", "memory image (R7)", 64'(bad_act), 64'(bad_exp));
    mm = 0; bad_act = '0; bad_exp = '0;
    for (int i = 0; i < n; i++) begin
      flag_raddr = 6'(i);
      #1;
      if (flag_rdata !== exp_flag[i]) begin
        if (mm == 0) begin bad_act = 32'(flag_rdata); bad_exp = 32'(exp_flag[i]); end
        mm++;
      end
    end
    check(mm == 0, "R4", "mark port (R9)", 64'(bad_act), 64'(bad_exp));
    mode = 2'd0;
  endtask

  typedef struct packed {
    logic [15:0] xl;
    logic [7:0]  len;
    logic [23:0] a0, a1, d0, d1;
    logic [1:0]  md;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd0,   8'd8,   24'h100000, 24'h100080, 24'h000300, 24'h000300, 2'd0, 8'd1},
    '{16'd20,  8'd13,  24'h0FF000, 24'h0FF800, 24'h000A00, 24'h000A00, 2'd1, 8'd2},
    '{16'd100, 8'd128, 24'h080000, 24'h080000, 24'h004000, 24'h004100, 2'd3, 8'd3},
    '{16'd7,   8'd1,   24'h000100, 24'h000100, 24'h000000, 24'h000000, 2'd2, 8'd4},
    '{16'd300, 8'd2,   24'h100000, 24'h130000, 24'hFFFF00, 24'hFFFE80, 2'd3, 8'd5},
    '{16'd60,  8'd37,  24'h0E0000, 24'h100000, 24'h001800, 24'hFFF000, 2'd0, 8'd9}
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: reset state
    check(!busy && !rd_req_valid && !wr_valid, "R1", "idle after reset",
          64'({busy, rd_req_valid, wr_valid}), 64'd0);
    check(!test_done && !write_done, "R8", "no pulses after reset",
          64'({test_done, write_done}), 64'd0);
    flag_raddr = 6'd0; #1;
    check(flag_rdata == 2'b00, "R9", "marks clear after reset", 64'(flag_rdata), 64'd0);

    // stimulus table
    for (int v = 0; v < NV; v++)
      run_span(VECS[v].xl, VECS[v].len, VECS[v].a0, VECS[v].a1, VECS[v].d0,
               VECS[v].d1, VECS[v].md, int'(VECS[v].seed), 1'b0);

    // R1: illegal lengths ignored
    @(negedge clk);
    span_len = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !rd_req_valid, "R1", "length 0 ignored", 64'(busy), 64'd0);
    span_len = 8'd129; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !rd_req_valid, "R1", "length 129 ignored", 64'(busy), 64'd0);

    // R4: equal depth is not closer, one-higher stored is
    run_span(16'd10, 8'd4, 24'h200000, 24'h200000, 24'h000000, 24'h000000, 2'd0, 0, 1'b0);
    flag_raddr = 6'd0; #1;
    check(flag_rdata == 2'b10, "R4", "strict less marks", 64'(flag_rdata), 64'h2);

    // R5: odd length masks the last odd half
    run_span(16'd40, 8'd5, 24'h000100, 24'h000100, 24'h000100, 24'h000100, 2'd0, 255, 1'b0);
    flag_raddr = 6'd2; #1;
    check(flag_rdata == 2'b01, "R5", "tail mark", 64'(flag_rdata), 64'h1);
    check(mem[22][31:16] == 16'hFFFF, "R5", "tail half untouched",
          64'(mem[22][31:16]), 64'hFFFF);

    // R10: start while busy ignored
    run_span(16'd80, 8'd24, 24'h0F8000, 24'h0F9000, 24'h000800, 24'h000600, 2'd3, 7, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule